// File: doc/BRIEF.md
# Sequential Signed/Unsigned Integer Multiplier

This block multiplies two operands one multiplier bit per clock. A start pulse captures the operands and a 3-bit operation code. The operands are reduced to magnitudes according to the signedness the operation assigns to each one. A 64-bit accumulator then runs a radix-2 shift-and-add loop over all 32 multiplier bits. At the end, the sign is restored and either the low or the high half of the product is presented.

The block serves the four multiply operations of a 32-bit integer core: low product, signed high, signed-by-unsigned high and unsigned high. The core stalls while the loop runs and writes the result back when the one-cycle done pulse appears. Once a start has been accepted, the operand and operation inputs are no longer looked at. The result stays on the output until the next start.

Top module: `mulseq_top`

## Requirements
- R1: Operation code 000 returns the low 32 bits of the product. The low half is the same for signed and unsigned operands.
- R2: Operation code 001 returns the high 32 bits of the product with both operands treated as two's-complement signed.
- R3: Operation code 010 returns the high 32 bits with operand a signed and operand b unsigned. An operand treated as unsigned is never negated.
- R4: Operation code 011 returns the high 32 bits with both operands unsigned.
- R5: A signed operand equal to 0x80000000 is taken as magnitude 2^31. MULH of 0x80000000 by 0x80000000 gives 0x40000000. MULHU of the same operands gives 0x40000000, and their MUL gives 0.
- R6: done is high in the cycle after the 33rd rising edge, counting the edge that accepts start as the first.
- R7: done is high for exactly one cycle. The block is then idle again and accepts a new start.
- R8: The operands and operation code present at the accepted start edge are the ones used. Later changes on those inputs do not alter the result.
- R9: start is ignored from the accepted edge until the block is idle again. Neither the result nor the done timing changes.
- R10: After synchronous reset, done is 0 and result is 0.
- R11: After done, result holds its value until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation; accepted only when idle |
| op | input | 3 | Operation code (000 MUL, 001 MULH, 010 MULHSU, 011 MULHU) |
| a | input | 32 | Multiplicand operand |
| b | input | 32 | Multiplier operand |
| result | output | 32 | Selected product half |
| done | output | 1 | One-cycle completion pulse |

## Verification
Small positive operands confirm the basic shift-and-add path and low-half selection. Mixed-sign and double-negative products separate a missing or extra sign correction. The same bit pattern is run under the three high-half codes, which tells apart the operand that should be negated from the one that must stay unsigned. Zero operands and 0x80000000 squared probe the empty product and the magnitude that overflows a signed negation. Runs that change the inputs or pulse start mid-loop show that capture happens only at the accepted edge.

// File: rtl/mulseq_pkg.sv
package mulseq_pkg;

    localparam logic [2:0] OP_MUL    = 3'b000;
    localparam logic [2:0] OP_MULH   = 3'b001;
    localparam logic [2:0] OP_MULHSU = 3'b010;
    localparam logic [2:0] OP_MULHU  = 3'b011;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_BIT  = 2'd1,
        PH_FIN  = 2'd2
    } phase_e;

    function automatic logic a_is_signed(input logic [2:0] op);
        return (op[1:0] == OP_MULH[1:0]) || (op[1:0] == OP_MULHSU[1:0]);
    endfunction

    function automatic logic b_is_signed(input logic [2:0] op);
        return op[1:0] == OP_MULH[1:0];
    endfunction

    function automatic logic want_high(input logic [2:0] op);
        return op[1:0] != OP_MUL[1:0];
    endfunction

endpackage

// File: rtl/mulseq_prep.sv
module mulseq_prep
    import mulseq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] mag_a,
    output logic [W-1:0] mag_b,
    output logic         neg
);
    localparam logic [W-1:0] MAG_MAX = {1'b1, {(W-1){1'b0}}};

    logic sa, sb, na, nb;

    always_comb begin
        sa    = a_is_signed(op);
        sb    = b_is_signed(op);
        na    = sa && a[W-1];
        nb    = sb && b[W-1];
        mag_a = na ? (~a + 1'b1) : a;
        mag_b = nb ? (~b + 1'b1) : b;
        neg   = na ^ nb;
    end

    // R5: a signed operand never yields a magnitude above 2^(W-1)
    always_comb begin
        if (sa) a_r5_mag_a_range: assert (mag_a <= MAG_MAX);
        if (sb) a_r5_mag_b_range: assert (mag_b <= MAG_MAX);
    end

endmodule

// File: rtl/mulseq_core.sv
module mulseq_core
    import mulseq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic           clk,
    input  logic           rst,
    input  logic           start,
    input  logic [W-1:0]   mag_a,
    input  logic [W-1:0]   mag_b,
    output logic [2*W-1:0] acc,
    output logic           idle,
    output logic           fin
);
    localparam int PW = 2 * W;
    localparam int CW = (W > 1) ? $clog2(W) : 1;
    localparam logic [CW-1:0] LAST = CW'(W - 1);

    phase_e        phase;
    logic [CW-1:0] idx;
    logic [PW-1:0] mcand;
    logic [W-1:0]  mplier;

    always_ff @(posedge clk) begin
        if (rst) begin
            phase  <= PH_IDLE;
            idx    <= '0;
            acc    <= '0;
            mcand  <= '0;
            mplier <= '0;
        end else begin
            unique case (phase)
                PH_IDLE: begin
                    if (start) begin
                        mcand  <= {{W{1'b0}}, mag_a};
                        mplier <= mag_b;
                        acc    <= '0;
                        idx    <= '0;
                        phase  <= PH_BIT;
                    end
                end
                PH_BIT: begin
                    if (mplier[0]) acc <= acc + mcand;
                    mcand  <= mcand << 1;
                    mplier <= mplier >> 1;
                    idx    <= idx + 1'b1;
                    if (idx == LAST) phase <= PH_FIN;
                end
                default: phase <= PH_IDLE;
            endcase
        end
    end

    assign idle = (phase == PH_IDLE);
    assign fin  = (phase == PH_FIN);

    // R7: completion lasts one cycle and is followed by idle
    a_r7_fin_pulse: assert property (@(posedge clk) disable iff (rst)
        fin |=> (idle && !fin));

    // R6: the bit walk advances one index per clock
    a_r6_bit_step: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BIT && idx != LAST) |=> (phase == PH_BIT && idx == $past(idx) + 1'b1));

    // R9: no restart of the bit walk while it is running
    a_r9_no_restart: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_BIT) |=> !(phase == PH_BIT && idx == '0));

endmodule

// File: rtl/mulseq_fmt.sv
module mulseq_fmt
    import mulseq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic [2*W-1:0] acc,
    input  logic           neg,
    input  logic [2:0]     op,
    output logic [W-1:0]   result
);
    logic [2*W-1:0] prod;

    always_comb begin
        prod   = neg ? (~acc + 1'b1) : acc;
        result = want_high(op) ? prod[2*W-1:W] : prod[W-1:0];
    end

endmodule

// File: rtl/mulseq_top.sv
module mulseq_top
    import mulseq_pkg::*;
#(
    parameter int W = 32
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         start,
    input  logic [2:0]   op,
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    output logic [W-1:0] result,
    output logic         done
);
    logic [W-1:0]   mag_a, mag_b;
    logic           neg_in, neg_q, idle;
    logic [2:0]     op_q;
    logic [2*W-1:0] acc;

    mulseq_prep #(.W(W)) u_prep (
        .op(op), .a(a), .b(b),
        .mag_a(mag_a), .mag_b(mag_b), .neg(neg_in)
    );

    mulseq_core #(.W(W)) u_core (
        .clk(clk), .rst(rst), .start(start),
        .mag_a(mag_a), .mag_b(mag_b),
        .acc(acc), .idle(idle), .fin(done)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            op_q  <= OP_MUL;
            neg_q <= 1'b0;
        end else if (idle && start) begin
            op_q  <= op;
            neg_q <= neg_in;
        end
    end

    mulseq_fmt #(.W(W)) u_fmt (
        .acc(acc), .neg(neg_q), .op(op_q), .result(result)
    );

    // R11: output holds while idle with no new start
    a_r11_hold: assert property (@(posedge clk) disable iff (rst)
        (idle && !start && !$past(rst)) |=> $stable(result));

endmodule

// File: tb/mulseq_top_tb.sv
module mulseq_top_tb;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        start = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [31:0] a = '0, b = '0;
    logic [31:0] result;
    logic        done;
    int n_chk = 0, n_fail = 0;
    bit  finished = 0;

    always #5 clk = ~clk;

    mulseq_top u_dut (.clk(clk), .rst(rst), .start(start), .op(op),
                      .a(a), .b(b), .result(result), .done(done));

    function automatic logic [31:0] ref_mul(input logic [2:0] o, input logic [31:0] x, input logic [31:0] y);
        logic [63:0] ex, ey, p;
        ex = (o[1:0] == 2'b01 || o[1:0] == 2'b10) ? {{32{x[31]}}, x} : {32'b0, x};
        ey = (o[1:0] == 2'b01) ? {{32{y[31]}}, y} : {32'b0, y};
        p  = ex * ey;
        return (o[1:0] == 2'b00) ? p[31:0] : p[63:32];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // one operation; optionally scramble inputs or pulse start mid-loop
    task automatic run(input string req, input logic [2:0] o, input logic [31:0] x,
                       input logic [31:0] y, input bit scramble, input bit restart);
        int n;
        logic [31:0] r;
        @(negedge clk);
        op = o; a = x; b = y; start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        if (scramble) begin a = ~x; b = y + 32'd7; op = o ^ 3'b011; end
        n = 1;
        while (!done && n < 100) begin
            if (restart && n == 10) start = 1'b1;
            if (restart && n == 11) start = 1'b0;
            @(negedge clk);
            n++;
        end
        start = 1'b0;
        check(req, result, ref_mul(o, x, y));
        check("R6 latency", 32'(n), 32'd33);
        r = result;
        @(negedge clk);
        check("R7 done width", {31'b0, done}, 32'd0);
        repeat (3) @(negedge clk);
        check("R11 hold", result, r);
    endtask

    task automatic t_reset();
        @(negedge clk);
        check("R10 done", {31'b0, done}, 32'd0);
        check("R10 result", result, 32'd0);
    endtask

    task automatic t_mul();
        run("R1 10x20", 3'b000, 32'd10, 32'd20, 0, 0);
        run("R1 -10x25", 3'b000, -32'sd10, 32'd25, 0, 0);
        run("R1 -8x-6", 3'b000, -32'sd8, -32'sd6, 0, 0);
        run("R1 0x0", 3'b000, 32'd0, 32'd0, 0, 0);
    endtask

    task automatic t_high();
        run("R2 mulh -10x25", 3'b001, -32'sd10, 32'd25, 0, 0);
        run("R2 mulh -8x-6", 3'b001, -32'sd8, -32'sd6, 0, 0);
        run("R2 mulh big", 3'b001, 32'h7fff_1234, 32'h8000_0001, 0, 0);
        run("R3 mulhsu neg a", 3'b010, 32'hffff_fff0, 32'hffff_ffff, 0, 0);
        run("R3 mulhsu b msb", 3'b010, 32'h1234_5678, 32'h9abc_def0, 0, 0);
        run("R4 mulhu", 3'b011, 32'hffff_ffff, 32'hffff_ffff, 0, 0);
        run("R4 mulhu mix", 3'b011, 32'hdead_beef, 32'h0000_1000, 0, 0);
    endtask

    task automatic t_minval();
        run("R5 mulh min*min", 3'b001, 32'h8000_0000, 32'h8000_0000, 0, 0);
        check("R5 mulh value", result, 32'h4000_0000);
        run("R5 mulhu min*min", 3'b011, 32'h8000_0000, 32'h8000_0000, 0, 0);
        check("R5 mulhu value", result, 32'h4000_0000);
        run("R5 mul min*min", 3'b000, 32'h8000_0000, 32'h8000_0000, 0, 0);
        run("R5 mulhsu min*min", 3'b010, 32'h8000_0000, 32'h8000_0000, 0, 0);
    endtask

    task automatic t_capture();
        run("R8 scrambled inputs", 3'b001, -32'sd12345, 32'd678901, 1, 0);
        run("R9 start mid-loop", 3'b011, 32'hcafe_f00d, 32'h0bad_cafe, 0, 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_mul();
        t_high();
        t_minval();
        t_capture();
        if (!finished) begin
            finished = 1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        #200000;
        if (!finished) begin
            finished = 1;
            n_chk++; n_fail++;
            $display("FAIL watchdog actual=timeout expected=finish");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule